// File: doc/BRIEF.md
# UART FIFO DMA Request Controller

This block sits between a UART's receive and transmit paths and a system DMA engine. It holds received bytes in a 64-entry receive FIFO and bytes waiting to be sent in a 64-entry transmit FIFO. It raises a receive DMA request and a transmit DMA request, both governed by programmable thresholds. A request that has been raised stays high for one whole burst. It drops only after the DMA side has moved exactly the threshold number of bytes.

The deserializer presents a received byte with a one-cycle valid strobe. The DMA engine takes received bytes with a read strobe and delivers transmit bytes with a write strobe. The serializer takes the next transmit byte with a pop strobe. A small register port sets both thresholds, the character length in bit-clock ticks, and the interrupt enables. Through the same port, software can poll receive data and read and clear the status flags.

A burst threshold above one can leave a few bytes stranded in the receive FIFO. For this case a character-timeout flag is raised, and software then drains the remainder by polled reads.

Top module: `uart_fifo_dma_req`

## Requirements
- R1: Each FIFO holds up to 64 bytes and delivers them in arrival order. A receive pop happens on a DMA read strobe, or on a register read of address 0, whenever the receive FIFO is not empty. A transmit pop happens on txPop whenever the transmit FIFO is not empty.
- R2: When no receive burst is open, the receive request rises on the second clock edge after the FIFO level first reaches the receive threshold. It stays low while the level is below the threshold.
- R3: Once raised, the receive request stays high until the DMA side has made exactly threshold-many reads from a non-empty FIFO. It goes low on the clock edge of the last of those reads. Polled reads do not count toward the burst.
- R4: When no transmit burst is open, the transmit request is raised while the free space (64 minus the level) is at least the transmit threshold. It stays high until threshold-many DMA writes have been accepted, and goes low on the edge of the last one. A write to a full transmit FIFO is dropped.
- R5: A threshold write of 0 is stored as 1, and a write above 64 is stored as 64. The receive threshold resets to 48 and the transmit threshold resets to 1. A ticks-per-character write of 0 is stored as 1, and this register resets to 10.
- R6: The timeout flag (status bit 1) is set after 4 x ticks-per-character bitTick pulses with no push and no pop, provided the receive level is above 0 and below the threshold. Any push or pop clears the flag and restarts the count.
- R7: Status bit 0 (receive-data cause) is set when a receive burst opens and is cleared by the next DMA read.
- R8: A byte that arrives while the receive FIFO is full is dropped, and status bit 2 (overrun) is set. The overrun flag stays set until software writes 1 to bit 2 of address 4.
- R9: irq is high when status bit 0 is set and enable bit 0 is set, or when status bit 1 is set and enable bit 7 is set. The enable register is at address 3 and resets to 0.
- R10: The register map is as follows. Address 1 holds the receive threshold and address 2 the transmit threshold. Address 3 holds the interrupt enables. Address 4 holds the status. Address 5 holds ticks per character. Register reads at addresses other than 0 have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One pulse per serial bit time |
| rxByteValid | input | 1 | Received byte strobe from the deserializer |
| rxByte | input | 8 | Received byte |
| dmaRxRead | input | 1 | DMA read strobe for receive data |
| rxData | output | 8 | Head of the receive FIFO |
| rxDmaReq | output | 1 | Receive DMA request |
| dmaTxWrite | input | 1 | DMA write strobe for transmit data |
| dmaTxData | input | 8 | Transmit byte from the DMA engine |
| txDmaReq | output | 1 | Transmit DMA request |
| txPop | input | 1 | Serializer takes the head transmit byte |
| txByte | output | 8 | Head of the transmit FIFO |
| txValid | output | 1 | Transmit FIFO not empty |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops receive data at address 0) |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four properties. The FIFO levels never exceed the depth. A request falls only right after a DMA strobe of its own direction. The receive request is never high with an empty FIFO, and the transmit request is never high with a full one. A byte offered to a full receive FIFO leaves the level unchanged. Some properties can only be shown by the bench scenarios, which sweep every threshold from 1 to 64. These are the exact burst length, the data order, the threshold clamping, the length of the timeout window and its restart, and the way the interrupt causes are set and cleared.

// File: rtl/uartdma_pkg.sv
package uartdma_pkg;
  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic txPush;
    logic txPop;
  } fifoStrobe_t;

  localparam logic [2:0] ADDR_DATA   = 3'd0;
  localparam logic [2:0] ADDR_RXTHR  = 3'd1;
  localparam logic [2:0] ADDR_TXTHR  = 3'd2;
  localparam logic [2:0] ADDR_IEN    = 3'd3;
  localparam logic [2:0] ADDR_STATUS = 3'd4;
  localparam logic [2:0] ADDR_TPC    = 3'd5;
endpackage

// File: rtl/uartdma_fifo.sv
module uartdma_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LVLW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [LVLW-1:0]  level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + LVLW'(1);
        2'b01:   level <= level - LVLW'(1);
        default: level <= level;
      endcase
    end
  end

  assign dout = mem[rdPtr];
endmodule

// File: rtl/uartdma_datapath.sv
module uartdma_datapath
  import uartdma_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  fifoStrobe_t     strobe,
  input  logic [7:0]      rxByte,
  input  logic [7:0]      txWdata,
  output logic [7:0]      rxHead,
  output logic [7:0]      txHead,
  output logic [LVLW-1:0] rxLevel,
  output logic [LVLW-1:0] txLevel
);
  logic [1:0]      pushV, popV;
  logic [7:0]      dinV  [2];
  logic [7:0]      doutV [2];
  logic [LVLW-1:0] lvlV  [2];

  assign pushV = {strobe.txPush, strobe.rxPush};
  assign popV  = {strobe.txPop,  strobe.rxPop};
  assign dinV[0] = rxByte;
  assign dinV[1] = txWdata;

  for (genvar g = 0; g < 2; g++) begin : gFifo
    uartdma_fifo #(.DEPTH(DEPTH), .WIDTH(8)) uFifo (
      .clk(clk), .rstN(rstN),
      .push(pushV[g]), .pop(popV[g]),
      .din(dinV[g]), .dout(doutV[g]), .level(lvlV[g])
    );
  end

  assign rxHead  = doutV[0];
  assign txHead  = doutV[1];
  assign rxLevel = lvlV[0];
  assign txLevel = lvlV[1];
endmodule

// File: rtl/uartdma_control.sv
module uartdma_control
  import uartdma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TPCW = 8,
  localparam int LVLW = $clog2(DEPTH) + 1,
  localparam int TMOW = TPCW + 2,
  localparam int RXTHR_RST = (DEPTH * 3) / 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bitTick,
  input  logic            rxByteValid,
  input  logic            dmaRxRead,
  input  logic            dmaTxWrite,
  input  logic            txPopIn,
  input  logic            regWe,
  input  logic            regRe,
  input  logic [2:0]      regAddr,
  input  logic [7:0]      regWdata,
  input  logic [7:0]      rxHead,
  input  logic [LVLW-1:0] rxLevel,
  input  logic [LVLW-1:0] txLevel,
  output fifoStrobe_t     strobe,
  output logic            rxDmaReq,
  output logic            txDmaReq,
  output logic [7:0]      regRdata,
  output logic            irq
);
  logic [LVLW-1:0] rxThr, txThr, rxCnt, txCnt, txFree;
  logic [TPCW-1:0] tpcReg;
  logic [TMOW-1:0] tmoCnt, tmoLimit;
  logic [7:0]      ienReg;
  logic            rxBurst, txBurst, rxCause, tmoFlag, ovrFlag;
  logic            rxEmpty, rxFull, txFull, dmaRdOk, dmaWrOk, pollRd, tmoArmed;

  function automatic logic [LVLW-1:0] clampThr(input logic [7:0] v);
    if (v == 8'd0)             return LVLW'(1);
    else if (v > 8'(DEPTH))    return LVLW'(DEPTH);
    else                       return LVLW'(v);
  endfunction

  assign rxEmpty  = (rxLevel == '0);
  assign rxFull   = (rxLevel == LVLW'(DEPTH));
  assign txFull   = (txLevel == LVLW'(DEPTH));
  assign txFree   = LVLW'(DEPTH) - txLevel;
  assign pollRd   = regRe && (regAddr == ADDR_DATA);
  assign dmaRdOk  = dmaRxRead && !rxEmpty;
  assign dmaWrOk  = dmaTxWrite && !txFull;

  assign strobe.rxPush = rxByteValid && !rxFull;
  assign strobe.rxPop  = (dmaRxRead || pollRd) && !rxEmpty;
  assign strobe.txPush = dmaWrOk;
  assign strobe.txPop  = txPopIn && (txLevel != '0);

  // receive burst: opens at threshold, closes after threshold-many DMA reads
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBurst <= 1'b0;
      rxCnt   <= '0;
    end else if (rxBurst) begin
      if (dmaRdOk) begin
        rxCnt <= rxCnt + LVLW'(1);
        if ((rxCnt + LVLW'(1)) >= rxThr) rxBurst <= 1'b0;
      end
    end else if (rxLevel >= rxThr) begin
      rxBurst <= 1'b1;
      rxCnt   <= '0;
    end
  end

  // transmit burst: opens when room for a burst, closes after threshold-many writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBurst <= 1'b0;
      txCnt   <= '0;
    end else if (txBurst) begin
      if (dmaWrOk) begin
        txCnt <= txCnt + LVLW'(1);
        if ((txCnt + LVLW'(1)) >= txThr) txBurst <= 1'b0;
      end
    end else if (txFree >= txThr) begin
      txBurst <= 1'b1;
      txCnt   <= '0;
    end
  end

  assign rxDmaReq = rxBurst;
  assign txDmaReq = txBurst;

  // character timeout
  assign tmoArmed = !rxEmpty && (rxLevel < rxThr);
  assign tmoLimit = {tpcReg, 2'b00} - TMOW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmoCnt  <= '0;
      tmoFlag <= 1'b0;
    end else if (strobe.rxPush || strobe.rxPop || !tmoArmed) begin
      tmoCnt  <= '0;
      tmoFlag <= 1'b0;
    end else if (bitTick && !tmoFlag) begin
      if (tmoCnt == tmoLimit) tmoFlag <= 1'b1;
      else                    tmoCnt  <= tmoCnt + TMOW'(1);
    end
  end

  // cause flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCause <= 1'b0;
      ovrFlag <= 1'b0;
    end else begin
      if (!rxBurst && (rxLevel >= rxThr)) rxCause <= 1'b1;
      else if (dmaRdOk)                   rxCause <= 1'b0;
      if (rxByteValid && rxFull)          ovrFlag <= 1'b1;
      else if (regWe && (regAddr == ADDR_STATUS) && regWdata[2]) ovrFlag <= 1'b0;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxThr  <= LVLW'(RXTHR_RST);
      txThr  <= LVLW'(1);
      ienReg <= '0;
      tpcReg <= TPCW'(10);
    end else if (regWe) begin
      case (regAddr)
        ADDR_RXTHR: rxThr  <= clampThr(regWdata);
        ADDR_TXTHR: txThr  <= clampThr(regWdata);
        ADDR_IEN:   ienReg <= regWdata;
        ADDR_TPC:   tpcReg <= (regWdata == 8'd0) ? TPCW'(1) : TPCW'(regWdata);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_DATA:   regRdata = rxHead;
      ADDR_RXTHR:  regRdata = 8'(rxThr);
      ADDR_TXTHR:  regRdata = 8'(txThr);
      ADDR_IEN:    regRdata = ienReg;
      ADDR_STATUS: regRdata = {5'b0, ovrFlag, tmoFlag, rxCause};
      ADDR_TPC:    regRdata = 8'(tpcReg);
      default:     regRdata = 8'h00;
    endcase
  end

  assign irq = (rxCause && ienReg[0]) || (tmoFlag && ienReg[7]);
endmodule

// File: rtl/uart_fifo_dma_req.sv
module uart_fifo_dma_req
  import uartdma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TPCW = 8,
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       rxByteValid,
  input  logic [7:0] rxByte,
  input  logic       dmaRxRead,
  output logic [7:0] rxData,
  output logic       rxDmaReq,
  input  logic       dmaTxWrite,
  input  logic [7:0] dmaTxData,
  output logic       txDmaReq,
  input  logic       txPop,
  output logic [7:0] txByte,
  output logic       txValid,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq
);
  fifoStrobe_t     strobe;
  logic [7:0]      rxHead;
  logic [LVLW-1:0] rxLevel, txLevel;

  uartdma_datapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rxByte(rxByte), .txWdata(dmaTxData),
    .rxHead(rxHead), .txHead(txByte),
    .rxLevel(rxLevel), .txLevel(txLevel)
  );

  uartdma_control #(.DEPTH(DEPTH), .TPCW(TPCW)) uCtrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .rxByteValid(rxByteValid), .dmaRxRead(dmaRxRead),
    .dmaTxWrite(dmaTxWrite), .txPopIn(txPop),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .rxHead(rxHead), .rxLevel(rxLevel), .txLevel(txLevel),
    .strobe(strobe), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
    .regRdata(regRdata), .irq(irq)
  );

  assign rxData  = rxHead;
  assign txValid = (txLevel != '0);
endmodule

// File: rtl/uartdma_checker.sv
module uartdma_checker #(
  parameter int DEPTH = 64,
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            rxDmaReq,
  input logic            txDmaReq,
  input logic            dmaRxRead,
  input logic            dmaTxWrite,
  input logic            rxByteValid,
  input logic            regRe,
  input logic [LVLW-1:0] rxLevel,
  input logic [LVLW-1:0] txLevel
);
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel <= LVLW'(DEPTH)) && (txLevel <= LVLW'(DEPTH)));

  assert_rx_req_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |-> (rxLevel != '0));

  assert_rx_drop_on_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDmaReq) |-> $past(dmaRxRead));

  assert_tx_drop_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDmaReq) |-> $past(dmaTxWrite));

  assert_tx_req_room_R4: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> (txLevel != LVLW'(DEPTH)));

  assert_overrun_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && (rxLevel == LVLW'(DEPTH)) && !dmaRxRead && !regRe)
      |=> (rxLevel == LVLW'(DEPTH)));
endmodule

bind uart_fifo_dma_req uartdma_checker #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq),
  .dmaRxRead(dmaRxRead), .dmaTxWrite(dmaTxWrite), .rxByteValid(rxByteValid),
  .regRe(regRe), .rxLevel(rxLevel), .txLevel(txLevel)
);

// File: tb/sim_uart_fifo_dma_req.sv
module sim_uart_fifo_dma_req;
  logic clk = 1'b0, rstN = 1'b0;
  logic bitTick = 0, rxByteValid = 0, dmaRxRead = 0, dmaTxWrite = 0, txPop = 0;
  logic regWe = 0, regRe = 0;
  logic [7:0] rxByte = 0, dmaTxData = 0, regWdata = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] rxData, txByte, regRdata;
  logic rxDmaReq, txDmaReq, txValid, irq;
  int tests = 0, fails = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_dma_req u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxByteValid(rxByteValid),
    .rxByte(rxByte), .dmaRxRead(dmaRxRead), .rxData(rxData), .rxDmaReq(rxDmaReq),
    .dmaTxWrite(dmaTxWrite), .dmaTxData(dmaTxData), .txDmaReq(txDmaReq),
    .txPop(txPop), .txByte(txByte), .txValid(txValid), .regWe(regWe),
    .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regPeek(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pollRead(output logic [7:0] d);
    regAddr = 3'd0; regRe = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] v);
    rxByte = v; rxByteValid = 1'b1;
    @(negedge clk);
    rxByteValid = 1'b0;
  endtask

  task automatic dmaRead();
    dmaRxRead = 1'b1;
    @(negedge clk);
    dmaRxRead = 1'b0;
  endtask

  task automatic dmaWrite(input logic [7:0] v);
    dmaTxData = v; dmaTxWrite = 1'b1;
    @(negedge clk);
    dmaTxWrite = 1'b0;
  endtask

  task automatic popTx();
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [7:0] d;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // reset state (R10, R5, R9)
    chk("R10 rxDmaReq at reset", int'(rxDmaReq), 0);
    chk("R10 irq at reset", int'(irq), 0);
    chk("R10 txValid at reset", int'(txValid), 0);
    chk("R4 txDmaReq after reset", int'(txDmaReq), 1);
    regPeek(3'd1, d); chk("R5 rx thr reset", int'(d), 48);
    regPeek(3'd2, d); chk("R5 tx thr reset", int'(d), 1);
    regPeek(3'd3, d); chk("R9 ien reset", int'(d), 0);
    regPeek(3'd4, d); chk("R10 status reset", int'(d), 0);
    regPeek(3'd5, d); chk("R5 tpc reset", int'(d), 10);

    // clamping (R5)
    regWrite(3'd1, 8'd0);   regPeek(3'd1, d); chk("R5 rx thr 0", int'(d), 1);
    regWrite(3'd1, 8'd200); regPeek(3'd1, d); chk("R5 rx thr 200", int'(d), 64);
    regWrite(3'd1, 8'd65);  regPeek(3'd1, d); chk("R5 rx thr 65", int'(d), 64);
    regWrite(3'd1, 8'd64);  regPeek(3'd1, d); chk("R5 rx thr 64", int'(d), 64);
    regWrite(3'd2, 8'd0);   regPeek(3'd2, d); chk("R5 tx thr 0", int'(d), 1);
    regWrite(3'd2, 8'd99);  regPeek(3'd2, d); chk("R5 tx thr 99", int'(d), 64);
    regWrite(3'd5, 8'd0);   regPeek(3'd5, d); chk("R5 tpc 0", int'(d), 1);
    regWrite(3'd2, 8'd1);
    idle(2);

    // receive burst sweep over every threshold (R1, R2, R3, R7)
    for (int t = 1; t <= 64; t++) begin
      regWrite(3'd1, 8'(t));
      for (int i = 0; i < t - 1; i++) pushRx(8'((t * 3 + i) & 255));
      idle(1);
      chk("R2 no req below threshold", int'(rxDmaReq), 0);
      pushRx(8'((t * 3 + t - 1) & 255));
      idle(1);
      chk("R2 req at threshold", int'(rxDmaReq), 1);
      regPeek(3'd4, d); chk("R7 cause set", int'(d[0]), 1);
      for (int i = 0; i < t; i++) begin
        chk("R1 rx order", int'(rxData), (t * 3 + i) & 255);
        dmaRead();
        if (i == 0) begin
          regPeek(3'd4, d); chk("R7 cause cleared by read", int'(d[0]), 0);
        end
        chk("R3 req held for burst", int'(rxDmaReq), (i < t - 1) ? 1 : 0);
      end
      idle(1);
      chk("R3 no re-request when empty", int'(rxDmaReq), 0);
    end

    // transmit burst sweep over every threshold (R1, R4)
    for (int t = 1; t <= 64; t++) begin
      regWrite(3'd2, 8'(t));
      idle(1);
      chk("R4 tx req with empty fifo", int'(txDmaReq), 1);
      for (int i = 0; i < t; i++) begin
        dmaWrite(8'((t * 5 + i) & 255));
        chk("R4 tx req held for burst", int'(txDmaReq), (i < t - 1) ? 1 : 0);
      end
      idle(1);
      chk("R4 tx re-request by free space", int'(txDmaReq), ((64 - t) >= t) ? 1 : 0);
      for (int i = 0; i < t; i++) begin
        chk("R1 tx order", int'(txByte), (t * 5 + i) & 255);
        popTx();
      end
      chk("R1 tx empty after drain", int'(txValid), 0);
      idle(1);
    end

    // full transmit FIFO drops a write (R4)
    regWrite(3'd2, 8'd64);
    idle(1);
    for (int i = 0; i < 64; i++) dmaWrite(8'(i));
    idle(1);
    chk("R4 no req when full", int'(txDmaReq), 0);
    dmaWrite(8'hEE);
    for (int i = 0; i < 64; i++) begin
      chk("R4 full tx drops write", int'(txByte), i);
      popTx();
    end
    chk("R4 tx empty after full drain", int'(txValid), 0);

    // overrun (R8)
    regWrite(3'd1, 8'd64);
    for (int i = 0; i < 64; i++) pushRx(8'(i + 100));
    regPeek(3'd4, d); chk("R8 no overrun at exactly full", int'(d[2]), 0);
    pushRx(8'hEE);
    regPeek(3'd4, d); chk("R8 overrun set", int'(d[2]), 1);
    regWrite(3'd4, 8'h00);
    regPeek(3'd4, d); chk("R8 overrun sticky on write 0", int'(d[2]), 1);
    regWrite(3'd4, 8'h04);
    regPeek(3'd4, d); chk("R8 overrun cleared by write 1", int'(d[2]), 0);
    chk("R2 req on full fifo", int'(rxDmaReq), 1);
    for (int i = 0; i < 64; i++) begin
      chk("R8 dropped byte absent", int'(rxData), i + 100);
      dmaRead();
    end
    chk("R3 req dropped after 64", int'(rxDmaReq), 0);

    // receive-data interrupt (R9, R7)
    regWrite(3'd1, 8'd4);
    regWrite(3'd3, 8'h01);
    for (int i = 0; i < 4; i++) pushRx(8'(i));
    idle(1);
    chk("R9 irq from rx cause", int'(irq), 1);
    dmaRead();
    chk("R9 irq cleared by dma read", int'(irq), 0);
    for (int i = 0; i < 3; i++) dmaRead();

    // character timeout (R6, R9)
    regWrite(3'd1, 8'd48);
    regWrite(3'd5, 8'd2);
    regWrite(3'd3, 8'h00);
    for (int i = 0; i < 3; i++) pushRx(8'(i + 7));
    bitTick = 1'b1;
    idle(6);
    regPeek(3'd4, d); chk("R6 no timeout at 6 ticks", int'(d[1]), 0);
    idle(4);
    regPeek(3'd4, d); chk("R6 timeout after 8 ticks", int'(d[1]), 1);
    chk("R9 irq masked", int'(irq), 0);
    regWrite(3'd3, 8'h80);
    chk("R9 irq from timeout", int'(irq), 1);
    pollRead(d); chk("R1 poll read data", int'(d), 7);
    chk("R6 timeout cleared by read", int'(irq), 0);
    pollRead(d); chk("R1 poll read data", int'(d), 8);
    pollRead(d); chk("R1 poll read data", int'(d), 9);
    regPeek(3'd4, d); chk("R6 no timeout when empty", int'(d[1]), 0);

    // timeout restart on each byte (R6)
    bitTick = 1'b0;
    pushRx(8'd1);
    pushRx(8'd2);
    bitTick = 1'b1;
    idle(6);
    bitTick = 1'b0;
    pushRx(8'd3);
    bitTick = 1'b1;
    idle(6);
    regPeek(3'd4, d); chk("R6 restart on byte", int'(d[1]), 0);
    idle(3);
    regPeek(3'd4, d); chk("R6 timeout after restart", int'(d[1]), 1);
    bitTick = 1'b0;
    for (int i = 0; i < 3; i++) pollRead(d);
    chk("R3 polled reads raise no request", int'(rxDmaReq), 0);
    regPeek(3'd7, d); chk("R10 unmapped reads zero", int'(d), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    finished = 1'b1;
    $finish;
  end
endmodule